// File: doc/BRIEF.md
# Cyclic User-Data Buffer Serializer

This block keeps a small register file shared between a host parallel port and an internal cyclic reader. Four bytes of user data sit in the upper half of an eight-location map. On every audio-sample strobe the block sends out one user bit. One sample is one channel, not a stereo pair. Each byte is sent least significant bit first, and after every eight samples the next byte is loaded. After four bytes, which is 32 samples, the reader returns to the first byte.

A half-buffer flag in the status register shows which pair of bytes the reader is working through, so the host knows which pair it may rewrite. When the interrupt mask is set, every change of that flag drives the active-low interrupt output low for exactly one clock. The host can read or write any location at any time through its own port, independent of the internal reader.

Top module: `cyc_user_serializer`

## Requirements
- R1: After reset, `user_bit` is 0 and `irq_n` is 1. The half flag (status bit 0) is 1, the reader points at address 4, and every control and user-data location reads 0.
- R2: Address 0 is the read-only status register: bit 0 is the half flag, the other bits read 0, and writes to it are ignored. Addresses 1 to 3 are read/write control registers, and bit 0 of address 1 is the interrupt mask. Addresses 4 to 7 hold the read/write user-data bytes.
- R3: A strobe arriving while the bit count is 0 loads the byte at the reader address into the shifter. From that clock edge, `user_bit` shows bit 0 of the byte, and each later strobe moves it to the next higher bit.
- R4: The reader address advances by one after each load, visiting 4, 5, 6, 7 and then 4 again, so one full lap is 32 strobes.
- R5: Loading the byte at address 4 clears the half flag, and loading the byte at address 6 sets it. The flag holds its value at all other times.
- R6: At the same clock edge where the half flag changes, `irq_n` goes low if the mask was 1 just before that edge. It stays low for exactly one clock.
- R7: While the mask is 0, `irq_n` stays high even when the half flag changes.
- R8: In a cycle without a strobe, neither `user_bit` nor the half flag changes, whatever the host port does.
- R9: If the host writes a user byte at the same edge where the reader loads that byte, the old value is shifted out. The new value goes out on the next lap.
- R10: `host_rdata` reflects the addressed location combinationally, in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable (with host_en) |
| host_addr | input | 3 | Host location address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| sample_stb | input | 1 | One pulse per audio sample |
| user_bit | output | 1 | Serial user-data bit |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
Two functions can meet at one clock edge. A host write to a user byte can land on the edge where the reader loads that same byte, and a mask write can land on the edge where the half flag toggles. The bench steers its strobe count so that a load of address 5 coincides with a host write to address 5, and it changes the mask at flag-change edges. A reference model that reads the buffer before applying writes, and uses the mask as it was before the edge, judges every clock.

// File: rtl/cyc_user_serializer.sv
module cyc_user_serializer #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8,
  localparam int PW = $clog2(NUM_BYTES),
  localparam int AW = PW + 1,
  localparam int CW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              sample_stb,
  output logic              user_bit,
  output logic              irq_n
);

  localparam logic [PW-1:0] HALF = PW'(NUM_BYTES / 2);

  logic [BYTE_W-1:0] ubuf [NUM_BYTES];
  logic [BYTE_W-1:0] creg [1:NUM_BYTES-1];
  logic [PW-1:0]     rd_ptr;
  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              half_flag;
  logic              irq_q;

  wire irq_mask = creg[1][0];
  wire load     = sample_stb && (bit_cnt == '0);
  wire to_low   = load && (rd_ptr == '0) && half_flag;
  wire to_high  = load && (rd_ptr == HALF) && !half_flag;
  wire host_wr  = host_en && host_we;
  wire [PW-1:0] idx = host_addr[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BYTES; i++) ubuf[i] <= '0;
      for (int i = 1; i < NUM_BYTES; i++) creg[i] <= '0;
    end else if (host_wr) begin
      if (host_addr[AW-1]) ubuf[idx] <= host_wdata;
      else if (idx != '0)  creg[idx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      half_flag <= 1'b1;
      irq_q     <= 1'b1;
    end else begin
      irq_q <= !((to_low || to_high) && irq_mask);
      if (to_low)  half_flag <= 1'b0;
      if (to_high) half_flag <= 1'b1;
      if (sample_stb) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (load) begin
          shreg  <= ubuf[rd_ptr];
          rd_ptr <= rd_ptr + 1'b1;
        end else begin
          shreg <= shreg >> 1;
        end
      end
    end
  end

  always_comb begin
    if (host_addr[AW-1])  host_rdata = ubuf[idx];
    else if (idx == '0)   host_rdata = {{(BYTE_W-1){1'b0}}, half_flag};
    else                  host_rdata = creg[idx];
  end

  assign user_bit = shreg[0];
  assign irq_n    = irq_q;

endmodule

// File: rtl/cyc_user_serializer_chk.sv
module cyc_user_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_stb,
  input logic user_bit,
  input logic irq_n,
  input logic half_flag,
  input logic irq_mask
);

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> irq_n);

  a_r6_irq_needs_flag_change: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (half_flag != $past(half_flag)));

  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(irq_mask));

  a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(user_bit));

  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(half_flag));

endmodule

bind cyc_user_serializer cyc_user_serializer_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .user_bit   (user_bit),
  .irq_n      (irq_n),
  .half_flag  (half_flag),
  .irq_mask   (irq_mask)
);

// File: tb/test_cyc_user_serializer.sv
module test_cyc_user_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_en = 1'b0, host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sample_stb = 1'b0;
  logic       user_bit, irq_n;

  cyc_user_serializer i_cyc_user_serializer (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sample_stb(sample_stb), .user_bit(user_bit), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_buf [4];
  logic [7:0] m_ctl [4];
  int   m_ptr, m_cnt;
  logic [7:0] m_sh;
  logic m_flag, m_irq;
  string bit_tag = "R3";

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(int a);
    if (a >= 4) return m_buf[a-4];
    if (a == 0) return {7'b0, m_flag};
    return m_ctl[a];
  endfunction

  task automatic step(bit stb, bit en, bit we, int a, logic [7:0] wd);
    bit old_mask;
    sample_stb = stb; host_en = en; host_we = we;
    host_addr = 3'(a); host_wdata = wd;
    #1;
    if (en && !we) chk(a == 0 ? "R5 status" : "R10 read", host_rdata, m_read(a));
    @(posedge clk);
    old_mask = m_ctl[1][0];
    m_irq = 1'b1;
    if (stb) begin
      if (m_cnt == 0) begin
        m_sh = m_buf[m_ptr];
        if (m_ptr == 0 && m_flag) begin m_flag = 0; m_irq = !old_mask; end
        if (m_ptr == 2 && !m_flag) begin m_flag = 1; m_irq = !old_mask; end
        m_ptr = (m_ptr + 1) % 4;
      end else m_sh = m_sh >> 1;
      m_cnt = (m_cnt + 1) % 8;
    end
    if (en && we) begin
      if (a >= 4) m_buf[a-4] = wd;
      else if (a != 0) m_ctl[a] = wd;
    end
    @(negedge clk);
    sample_stb = 0; host_en = 0; host_we = 0;
    chk(bit_tag, user_bit, m_sh[0]);
    chk(old_mask ? "R6 irq" : "R7 irq masked", irq_n, m_irq);
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step(1, 1, 0, 0, 0);
      for (int g = 0; g < gap; g++) step(0, 1, 1, 2, 8'($urandom));
    end
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_buf[i] = 0; m_ctl[i] = 0; end
    m_ptr = 0; m_cnt = 0; m_sh = 0; m_flag = 1; m_irq = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 user_bit", user_bit, 0);
    chk("R1 irq_n", irq_n, 1);
    for (int a = 0; a < 8; a++) step(0, 1, 0, a, 0);
    chk("R1 flag", m_flag, 1);

    step(0, 1, 1, 4, 8'hA5); step(0, 1, 1, 5, 8'h3C);
    step(0, 1, 1, 6, 8'hF0); step(0, 1, 1, 7, 8'h81);
    step(0, 1, 1, 1, 8'h01); step(0, 1, 1, 3, 8'hC3);
    step(0, 1, 1, 0, 8'hFF);
    host_addr = 0; #1;
    chk("R2 status write ignored", host_rdata, 8'h01);
    @(negedge clk);
    for (int a = 0; a < 8; a++) step(0, 1, 0, a, 0);

    bit_tag = "R3";
    run(8, 2);
    bit_tag = "R4";
    run(36, 1);

    bit_tag = "R9";
    while (!(m_cnt == 0 && m_ptr == 1)) step(1, 0, 0, 0, 0);
    step(1, 1, 1, 5, 8'h77);
    run(40, 0);

    bit_tag = "R8";
    run(10, 3);

    bit_tag = "R7";
    while (!(m_cnt == 0 && m_ptr == 2)) step(1, 0, 0, 0, 0);
    step(1, 1, 1, 1, 8'h00);
    run(40, 0);
    while (!(m_cnt == 0 && m_ptr == 0)) step(1, 0, 0, 0, 0);
    step(1, 1, 1, 1, 8'h01);
    run(20, 1);

    bit_tag = "R4";
    for (int i = 0; i < 200; i++) step(1'($urandom), 1, 1'($urandom), int'($urandom_range(0, 7)), 8'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule